// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the control unit of a 32-bit processor whose datapath shares one internal bus. A small step counter walks through numbered time steps. In every cycle the block combines the current step with the 5-bit opcode into a vector of datapath strobes. The strobes select which register drives the bus, which registers capture it, what the ALU does, and whether a memory read or write is requested. The register file, ALU, counters and memory sit outside. They see the control unit only through this vector, and they return two things: a memory completion flag and a zero flag from the shift count register.

Every instruction starts with the same three fetch steps (0, 1 and 2). Execution begins at step 3. A wait strobe holds the counter until memory reports completion. An end strobe sends the counter back to step 0. A loop strobe sends it to step 6 so that a one-bit shift can repeat. A run flag gates all activity: a start pulse sets it and the stop opcode clears it. A pending, enabled interrupt request at step 0 replaces the fetch with a single vectoring cycle. While reset is high, the only strobe raised is a PC clear.

Top module: `hwcu_sequencer`

## Requirements
- R1: `ctl_o` bit map: 0 pc_out, 1 pc_in, 2 ma_in, 3 inc4, 4 c_in, 5 c_out, 6 md_out, 7 md_in, 8 ir_in, 9 a_in, 10 reg_out, 11 reg_in, 12 base_or_zero_out, 13 sel_ra, 14 sel_rb, 15 sel_rc, 16 alu_add, 17 imm_out, 18 mem_read, 19 mem_write, 20 wait, 21 end, 22 shift_right, 23 count_dec, 24 count_load, 25 count_field_out, 26 loop, 27 pass_b, 28 cond_load, 29 cond_pc_in, 30 save_pc, 31 irq_ack, 32 ie_clear, 33 vector_out, 34 pc_clear. At most one of the three register-field selects (bits 13, 14, 15) is high at a time.
- R2: While `rst` is high, `ctl_o` has only bit 34 set. The cycle after reset shows `step_o`=0 and `run_o`=0.
- R3: While the run flag is clear, `step_o` stays at 0 and `ctl_o` is all zero, whatever the other inputs are. A high `start_i` sets the run flag at the next edge.
- R4: The fetch steps raise these strobes. Step 0: pc_out, ma_in, inc4, c_in. Step 1: mem_read, c_out, pc_in, wait. Step 2: md_out, ir_in.
- R5: While the wait strobe is high and `mem_done_i` is low, the step does not change and the same strobes stay asserted.
- R6: If the end strobe is high and no stall applies, the next step is 0. Otherwise, with no stall, no interrupt cycle and no loop, the step advances by one.
- R7: add (opcode 12) and add-immediate (opcode 13). Step 3: sel_rb, reg_out, a_in. Step 4: alu_add and c_in, plus sel_rc with reg_out for add, or imm_out for add-immediate. Step 5: c_out, sel_ra, reg_in, end.
- R8: load (opcode 1) and store (opcode 3). Step 3: sel_rb, base_or_zero_out, a_in. Step 4: imm_out, alu_add, c_in. Step 5: c_out, ma_in. Load continues with step 6: mem_read, wait, and step 7: md_out, sel_ra, reg_in, end. Store continues with step 6: sel_ra, reg_out, md_in, mem_write, and step 7: wait, end.
- R9: branch (opcode 8). Step 3: sel_rc, reg_out, cond_load. Step 4: sel_rb, reg_out, cond_pc_in, end.
- R10: shift right (opcode 26). Step 3: count_field_out, count_load. Step 4: if `count_zero_i` is high, sel_rc, reg_out, count_load; otherwise nothing. Step 5: sel_rb, reg_out, pass_b, c_in. Step 6: if `count_zero_i` is low, c_out, shift_right, c_in, count_dec, loop, and the next step is 6 again; otherwise nothing. Step 7: c_out, sel_ra, reg_in, end.
- R11: nop (opcode 0), stop (opcode 31) and every opcode not named above raise only end at step 3. Stop also clears the run flag at that edge.
- R12: At step 0, a high `irq_req_i` together with a high `irq_en_i` replaces the fetch with save_pc, irq_ack, ie_clear, vector_out and pc_in. The step stays 0. With `irq_en_i` low, or outside step 0, the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sets the run flag |
| op_i | input | 5 | Opcode field of the instruction register |
| mem_done_i | input | 1 | Memory completion |
| count_zero_i | input | 1 | Shift count register is zero |
| irq_req_i | input | 1 | Interrupt request |
| irq_en_i | input | 1 | Interrupt enable flag |
| ctl_o | output | 35 | Datapath strobe vector (map in R1) |
| step_o | output | STEP_W | Current control step |
| run_o | output | 1 | Run flag |

## Verification
The hardest case is stacking the conditional events: a shift that loops several times at step 6, a memory access that stalls at step 1 or step 7, and an interrupt request that is held high across a whole instruction but may only be taken at step 0. The bench runs a directed program first. It sets the memory latency per instruction and sets the number of shift iterations through the count-zero flag. Then it keeps the same reference model running under seeded random latency, interrupt, start and reset traffic. The opcode is changed only at instruction boundaries, so every sequence runs to its end.

// File: rtl/hwcu_pkg.sv
package hwcu_pkg;

    localparam int OP_W            = 5;
    localparam int NUM_STROBES     = 35;
    localparam int EXEC_FIRST_STEP = 3;
    localparam int SHIFT_LOOP_STEP = 6;

    typedef enum logic [5:0] {
        S_PC_OUT  = 6'd0,  S_PC_IN   = 6'd1,  S_MA_IN   = 6'd2,  S_INC4    = 6'd3,
        S_C_IN    = 6'd4,  S_C_OUT   = 6'd5,  S_MD_OUT  = 6'd6,  S_MD_IN   = 6'd7,
        S_IR_IN   = 6'd8,  S_A_IN    = 6'd9,  S_R_OUT   = 6'd10, S_R_IN    = 6'd11,
        S_BA_OUT  = 6'd12, S_G_RA    = 6'd13, S_G_RB    = 6'd14, S_G_RC    = 6'd15,
        S_ADD     = 6'd16, S_IMM_OUT = 6'd17, S_READ    = 6'd18, S_WRITE   = 6'd19,
        S_WAIT    = 6'd20, S_END     = 6'd21, S_SHR     = 6'd22, S_DEC     = 6'd23,
        S_LD_CNT  = 6'd24, S_FLD_OUT = 6'd25, S_LOOP    = 6'd26, S_PASS_B  = 6'd27,
        S_CON_IN  = 6'd28, S_CON_PC  = 6'd29, S_IPC_IN  = 6'd30, S_IACK    = 6'd31,
        S_IE_CLR  = 6'd32, S_VEC_OUT = 6'd33, S_PC_CLR  = 6'd34
    } strobe_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'd0,
        OP_LD   = 5'd1,
        OP_ST   = 5'd3,
        OP_BR   = 5'd8,
        OP_ADD  = 5'd12,
        OP_ADDI = 5'd13,
        OP_SHR  = 5'd26,
        OP_STOP = 5'd31
    } opcode_e;

    typedef logic [NUM_STROBES-1:0] ctl_vec_t;

    // Common fetch steps 0..2
    function automatic ctl_vec_t fetch_seq(input int t);
        ctl_vec_t c;
        c = '0;
        case (t)
            0: begin
                c[S_PC_OUT] = 1'b1; c[S_MA_IN] = 1'b1;
                c[S_INC4]   = 1'b1; c[S_C_IN]  = 1'b1;
            end
            1: begin
                c[S_READ]  = 1'b1; c[S_C_OUT] = 1'b1;
                c[S_PC_IN] = 1'b1; c[S_WAIT]  = 1'b1;
            end
            2: begin
                c[S_MD_OUT] = 1'b1; c[S_IR_IN] = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Single vectoring cycle taken in place of a fetch
    function automatic ctl_vec_t irq_seq();
        ctl_vec_t c;
        c = '0;
        c[S_IPC_IN]  = 1'b1;
        c[S_IACK]    = 1'b1;
        c[S_IE_CLR]  = 1'b1;
        c[S_VEC_OUT] = 1'b1;
        c[S_PC_IN]   = 1'b1;
        return c;
    endfunction

    // Register/register or register/immediate addition
    function automatic ctl_vec_t alu_seq(input logic use_imm, input int t);
        ctl_vec_t c;
        c = '0;
        case (t)
            3: begin
                c[S_G_RB] = 1'b1; c[S_R_OUT] = 1'b1; c[S_A_IN] = 1'b1;
            end
            4: begin
                c[S_ADD]  = 1'b1; c[S_C_IN] = 1'b1;
                if (use_imm) begin
                    c[S_IMM_OUT] = 1'b1;
                end else begin
                    c[S_G_RC]  = 1'b1;
                    c[S_R_OUT] = 1'b1;
                end
            end
            5: begin
                c[S_C_OUT] = 1'b1; c[S_G_RA] = 1'b1;
                c[S_R_IN]  = 1'b1; c[S_END]  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Displacement load or store
    function automatic ctl_vec_t mem_seq(input logic is_store, input int t);
        ctl_vec_t c;
        c = '0;
        case (t)
            3: begin
                c[S_G_RB] = 1'b1; c[S_BA_OUT] = 1'b1; c[S_A_IN] = 1'b1;
            end
            4: begin
                c[S_IMM_OUT] = 1'b1; c[S_ADD] = 1'b1; c[S_C_IN] = 1'b1;
            end
            5: begin
                c[S_C_OUT] = 1'b1; c[S_MA_IN] = 1'b1;
            end
            6: begin
                if (is_store) begin
                    c[S_G_RA]  = 1'b1; c[S_R_OUT] = 1'b1;
                    c[S_MD_IN] = 1'b1; c[S_WRITE] = 1'b1;
                end else begin
                    c[S_READ] = 1'b1; c[S_WAIT] = 1'b1;
                end
            end
            7: begin
                if (is_store) begin
                    c[S_WAIT] = 1'b1; c[S_END] = 1'b1;
                end else begin
                    c[S_MD_OUT] = 1'b1; c[S_G_RA] = 1'b1;
                    c[S_R_IN]   = 1'b1; c[S_END]  = 1'b1;
                end
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Conditional branch
    function automatic ctl_vec_t br_seq(input int t);
        ctl_vec_t c;
        c = '0;
        case (t)
            3: begin
                c[S_G_RC] = 1'b1; c[S_R_OUT] = 1'b1; c[S_CON_IN] = 1'b1;
            end
            4: begin
                c[S_G_RB]   = 1'b1; c[S_R_OUT] = 1'b1;
                c[S_CON_PC] = 1'b1; c[S_END]   = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Logical shift right, one bit per pass through the loop step
    function automatic ctl_vec_t shift_seq(input int t, input logic cnt_zero);
        ctl_vec_t c;
        c = '0;
        case (t)
            3: begin
                c[S_FLD_OUT] = 1'b1; c[S_LD_CNT] = 1'b1;
            end
            4: begin
                if (cnt_zero) begin
                    c[S_G_RC] = 1'b1; c[S_R_OUT] = 1'b1; c[S_LD_CNT] = 1'b1;
                end
            end
            5: begin
                c[S_G_RB]   = 1'b1; c[S_R_OUT] = 1'b1;
                c[S_PASS_B] = 1'b1; c[S_C_IN]  = 1'b1;
            end
            SHIFT_LOOP_STEP: begin
                if (!cnt_zero) begin
                    c[S_C_OUT] = 1'b1; c[S_SHR]  = 1'b1; c[S_C_IN] = 1'b1;
                    c[S_DEC]   = 1'b1; c[S_LOOP] = 1'b1;
                end
            end
            7: begin
                c[S_C_OUT] = 1'b1; c[S_G_RA] = 1'b1;
                c[S_R_IN]  = 1'b1; c[S_END]  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hwcu_decode.sv
module hwcu_decode
    import hwcu_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              run_i,
    input  logic              count_zero_i,
    input  logic              irq_req_i,
    input  logic              irq_en_i,
    output ctl_vec_t          ctl_o,
    output logic              irq_take_o,
    output logic              stop_hit_o
);

    localparam int STEP_NUM = STEP_W;

    logic     at_boundary;
    logic     in_fetch;
    ctl_vec_t exec_ctl;
    int       t;

    assign t           = int'(step_i);
    assign at_boundary = (step_i == '0);
    assign in_fetch    = (t < EXEC_FIRST_STEP);
    assign irq_take_o  = run_i && at_boundary && irq_req_i && irq_en_i;
    assign stop_hit_o  = run_i && (t == EXEC_FIRST_STEP) && (op_i == OP_STOP);

    always_comb begin
        exec_ctl = '0;
        case (op_i)
            OP_ADD:  exec_ctl = alu_seq(1'b0, t);
            OP_ADDI: exec_ctl = alu_seq(1'b1, t);
            OP_LD:   exec_ctl = mem_seq(1'b0, t);
            OP_ST:   exec_ctl = mem_seq(1'b1, t);
            OP_BR:   exec_ctl = br_seq(t);
            OP_SHR:  exec_ctl = shift_seq(t, count_zero_i);
            default: begin
                if (t == EXEC_FIRST_STEP) begin
                    exec_ctl[S_END] = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        if (!run_i) begin
            ctl_o = '0;
        end else if (irq_take_o) begin
            ctl_o = irq_seq();
        end else if (in_fetch) begin
            ctl_o = fetch_seq(t);
        end else begin
            ctl_o = exec_ctl;
        end
    end

    // Register-field selects drive one shared decoder
    always_comb begin
        assert_field_select_onehot_R1: assert ($onehot0({ctl_o[S_G_RA], ctl_o[S_G_RB], ctl_o[S_G_RC]}))
            else $error("field selects not one-hot");
    end

    // Interrupt strobes never mix with the fetch
    always_comb begin
        assert_irq_excludes_fetch_R12: assert (!(ctl_o[S_IACK] && ctl_o[S_READ]))
            else $error("interrupt cycle overlaps a read");
    end

    initial begin
        assert_step_width_R6: assert (STEP_NUM >= 3)
            else $error("step counter too narrow for eight steps");
    end

endmodule

// File: rtl/hwcu_step_ctr.sv
module hwcu_step_ctr #(
    parameter int STEP_W    = 3,
    parameter int LOOP_STEP = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              stall_i,
    input  logic              hold_i,
    input  logic              end_i,
    input  logic              loop_i,
    output logic [STEP_W-1:0] step_o
);

    localparam logic [STEP_W-1:0] LOOP_VAL = STEP_W'(LOOP_STEP);

    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            step_q <= '0;
        end else if (stall_i || hold_i) begin
            step_q <= step_q;
        end else if (end_i) begin
            step_q <= '0;
        end else if (loop_i) begin
            step_q <= LOOP_VAL;
        end else begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step_o = step_q;

    assert_stall_holds_step_R5: assert property (@(posedge clk) disable iff (rst)
        (run_i && stall_i) |=> (step_q == $past(step_q)))
        else $error("step moved during a memory stall");

    assert_end_returns_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (run_i && end_i && !stall_i) |=> (step_q == '0))
        else $error("end strobe did not return to step 0");

    assert_loop_target_R10: assert property (@(posedge clk) disable iff (rst)
        (run_i && loop_i && !stall_i && !end_i && !hold_i) |=> (step_q == LOOP_VAL))
        else $error("loop strobe did not jump back");

    assert_irq_holds_boundary_R12: assert property (@(posedge clk) disable iff (rst)
        (run_i && hold_i) |=> (step_q == '0))
        else $error("interrupt cycle left step 0");

endmodule

// File: rtl/hwcu_run_ctl.sv
module hwcu_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_hit_i,
    output logic run_o
);

    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (stop_hit_i) begin
            run_q <= 1'b0;
        end else if (start_i) begin
            run_q <= 1'b1;
        end
    end

    assign run_o = run_q;

    assert_stop_clears_run_R11: assert property (@(posedge clk) disable iff (rst)
        stop_hit_i |=> !run_q)
        else $error("stop opcode left run set");

    assert_start_sets_run_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_q && start_i) |=> run_q)
        else $error("start did not set run");

endmodule

// File: rtl/hwcu_sequencer.sv
module hwcu_sequencer #(
    parameter int STEP_W = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start_i,
    input  logic [hwcu_pkg::OP_W-1:0]        op_i,
    input  logic                             mem_done_i,
    input  logic                             count_zero_i,
    input  logic                             irq_req_i,
    input  logic                             irq_en_i,
    output logic [hwcu_pkg::NUM_STROBES-1:0] ctl_o,
    output logic [STEP_W-1:0]                step_o,
    output logic                             run_o
);
    import hwcu_pkg::*;

    logic              run;
    logic [STEP_W-1:0] step;
    ctl_vec_t          dec_ctl;
    logic              irq_take;
    logic              stop_hit;
    logic              stall;

    hwcu_run_ctl u_run (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .stop_hit_i (stop_hit),
        .run_o      (run)
    );

    hwcu_decode #(.STEP_W(STEP_W)) u_dec (
        .step_i       (step),
        .op_i         (op_i),
        .run_i        (run),
        .count_zero_i (count_zero_i),
        .irq_req_i    (irq_req_i),
        .irq_en_i     (irq_en_i),
        .ctl_o        (dec_ctl),
        .irq_take_o   (irq_take),
        .stop_hit_o   (stop_hit)
    );

    assign stall = run && dec_ctl[S_WAIT] && !mem_done_i;

    hwcu_step_ctr #(.STEP_W(STEP_W), .LOOP_STEP(SHIFT_LOOP_STEP)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .stall_i (stall),
        .hold_i  (irq_take),
        .end_i   (dec_ctl[S_END]),
        .loop_i  (dec_ctl[S_LOOP]),
        .step_o  (step)
    );

    always_comb begin
        if (rst) begin
            ctl_o           = '0;
            ctl_o[S_PC_CLR] = 1'b1;
        end else begin
            ctl_o = dec_ctl;
        end
    end

    assign step_o = step;
    assign run_o  = run;

    assert_idle_is_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !run_o |-> (ctl_o == '0 && step_o == '0))
        else $error("strobes active while halted");

    assert_reset_pc_clear_R2: assert property (@(posedge clk)
        rst |-> (ctl_o[S_PC_CLR] && $countones(ctl_o) == 1))
        else $error("reset strobe set wrong");

endmodule

// File: tb/hwcu_sequencer_bench.sv
`timescale 1ns/1ps
module hwcu_sequencer_bench;

    localparam int NS = 35;
    localparam int SW = 3;
    localparam int HALF = 10;

    // R1 bit positions
    localparam int B_PC_OUT = 0,  B_PC_IN = 1,  B_MA_IN = 2,  B_INC4 = 3,  B_C_IN = 4;
    localparam int B_C_OUT = 5,   B_MD_OUT = 6, B_MD_IN = 7,  B_IR_IN = 8, B_A_IN = 9;
    localparam int B_R_OUT = 10,  B_R_IN = 11,  B_BA = 12,    B_GRA = 13,  B_GRB = 14;
    localparam int B_GRC = 15,    B_ADD = 16,   B_IMM = 17,   B_READ = 18, B_WRITE = 19;
    localparam int B_WAIT = 20,   B_END = 21,   B_SHR = 22,   B_DEC = 23,  B_LDC = 24;
    localparam int B_FLD = 25,    B_LOOP = 26,  B_PASSB = 27, B_CONIN = 28, B_CONPC = 29;
    localparam int B_IPC = 30,    B_IACK = 31,  B_IECLR = 32, B_VEC = 33,  B_PCCLR = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [4:0] op = 5'd0;
    logic mem_done = 1'b0;
    logic cz = 1'b0;
    logic irq = 1'b0;
    logic ie = 1'b0;
    logic [NS-1:0] ctl;
    logic [SW-1:0] step;
    logic run;

    int tests = 0;
    int fails = 0;
    int m_step = 0;
    bit m_run = 1'b0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    hwcu_sequencer #(.STEP_W(SW)) u_hwcu_sequencer (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .op_i         (op),
        .mem_done_i   (mem_done),
        .count_zero_i (cz),
        .irq_req_i    (irq),
        .irq_en_i     (ie),
        .ctl_o        (ctl),
        .step_o       (step),
        .run_o        (run)
    );

    function automatic logic [NS-1:0] exp_ctl(int st, int o, bit r, bit c, bit take);
        logic [NS-1:0] e;
        e = '0;
        if (!r) return e;
        if (take) begin
            e[B_IPC] = 1; e[B_IACK] = 1; e[B_IECLR] = 1; e[B_VEC] = 1; e[B_PC_IN] = 1;
            return e;
        end
        if (st == 0) begin e[B_PC_OUT] = 1; e[B_MA_IN] = 1; e[B_INC4] = 1; e[B_C_IN] = 1; return e; end
        if (st == 1) begin e[B_READ] = 1; e[B_C_OUT] = 1; e[B_PC_IN] = 1; e[B_WAIT] = 1; return e; end
        if (st == 2) begin e[B_MD_OUT] = 1; e[B_IR_IN] = 1; return e; end
        if (o == 12 || o == 13) begin
            if (st == 3) begin e[B_GRB] = 1; e[B_R_OUT] = 1; e[B_A_IN] = 1; end
            if (st == 4) begin
                e[B_ADD] = 1; e[B_C_IN] = 1;
                if (o == 13) e[B_IMM] = 1; else begin e[B_GRC] = 1; e[B_R_OUT] = 1; end
            end
            if (st == 5) begin e[B_C_OUT] = 1; e[B_GRA] = 1; e[B_R_IN] = 1; e[B_END] = 1; end
        end else if (o == 1 || o == 3) begin
            if (st == 3) begin e[B_GRB] = 1; e[B_BA] = 1; e[B_A_IN] = 1; end
            if (st == 4) begin e[B_IMM] = 1; e[B_ADD] = 1; e[B_C_IN] = 1; end
            if (st == 5) begin e[B_C_OUT] = 1; e[B_MA_IN] = 1; end
            if (st == 6 && o == 1) begin e[B_READ] = 1; e[B_WAIT] = 1; end
            if (st == 6 && o == 3) begin e[B_GRA] = 1; e[B_R_OUT] = 1; e[B_MD_IN] = 1; e[B_WRITE] = 1; end
            if (st == 7 && o == 1) begin e[B_MD_OUT] = 1; e[B_GRA] = 1; e[B_R_IN] = 1; e[B_END] = 1; end
            if (st == 7 && o == 3) begin e[B_WAIT] = 1; e[B_END] = 1; end
        end else if (o == 8) begin
            if (st == 3) begin e[B_GRC] = 1; e[B_R_OUT] = 1; e[B_CONIN] = 1; end
            if (st == 4) begin e[B_GRB] = 1; e[B_R_OUT] = 1; e[B_CONPC] = 1; e[B_END] = 1; end
        end else if (o == 26) begin
            if (st == 3) begin e[B_FLD] = 1; e[B_LDC] = 1; end
            if (st == 4 && c) begin e[B_GRC] = 1; e[B_R_OUT] = 1; e[B_LDC] = 1; end
            if (st == 5) begin e[B_GRB] = 1; e[B_R_OUT] = 1; e[B_PASSB] = 1; e[B_C_IN] = 1; end
            if (st == 6 && !c) begin
                e[B_C_OUT] = 1; e[B_SHR] = 1; e[B_C_IN] = 1; e[B_DEC] = 1; e[B_LOOP] = 1;
            end
            if (st == 7) begin e[B_C_OUT] = 1; e[B_GRA] = 1; e[B_R_IN] = 1; e[B_END] = 1; end
        end else begin
            if (st == 3) e[B_END] = 1;
        end
        return e;
    endfunction

    function automatic string ctl_tag(bit r, bit mr, bit take, int st, int o);
        if (r) return "R2";
        if (!mr) return "R3";
        if (take) return "R12";
        if (st < 3) return "R4";
        if (o == 12 || o == 13) return "R7";
        if (o == 1 || o == 3) return "R8";
        if (o == 8) return "R9";
        if (o == 26) return "R10";
        return "R11";
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cycle(bit r, bit s, int o, bit md, bit c, bit iq, bit ien);
        logic [NS-1:0] e;
        bit take, stall, stp;
        int ns;
        bit nr;
        string st_tag;
        @(negedge clk);
        rst = r; start = s; op = o[4:0]; mem_done = md; cz = c; irq = iq; ie = ien;
        #2;
        take = !r && m_run && m_step == 0 && iq && ien;
        if (r) begin
            e = '0;
            e[B_PCCLR] = 1'b1;
        end else begin
            e = exp_ctl(m_step, o, m_run, c, take);
        end
        check(ctl == e, ctl_tag(r, m_run, take, m_step, o), "ctl_o", 64'(ctl), 64'(e));
        check($onehot0({ctl[B_GRA], ctl[B_GRB], ctl[B_GRC]}), "R1", "field selects",
              64'({ctl[B_GRA], ctl[B_GRB], ctl[B_GRC]}), 64'(0));
        stall = m_run && e[B_WAIT] && !md;
        st_tag = stall ? "R5" : "R6";
        check(int'(step) == m_step, st_tag, "step_o", 64'(step), 64'(m_step));
        check(run == m_run, m_run ? "R11" : "R3", "run_o", 64'(run), 64'(m_run));
        stp = m_run && m_step == 3 && o == 31;
        if (r) begin
            ns = 0; nr = 1'b0;
        end else begin
            if (!m_run) ns = 0;
            else if (stall || take) ns = m_step;
            else if (e[B_END]) ns = 0;
            else if (e[B_LOOP]) ns = 6;
            else ns = m_step + 1;
            nr = stp ? 1'b0 : (s ? 1'b1 : m_run);
        end
        @(posedge clk);
        m_step = ns;
        m_run = nr;
    endtask

    // One instruction: lat = memory wait cycles, loops = shift passes
    task automatic instr(int o, int lat, int loops, bit iq, bit ien);
        int wcnt = 0;
        int left = loops;
        logic [NS-1:0] pre;
        bit md, c;
        for (int k = 0; k < 60; k++) begin
            pre = exp_ctl(m_step, o, m_run, 1'b0, 1'b0);
            if (pre[B_WAIT]) begin
                md = (wcnt >= lat);
                wcnt++;
            end else begin
                md = 1'b0;
                wcnt = 0;
            end
            c = (left == 0);
            if (m_step == 6 && left > 0 && o == 26) begin
                cycle(1'b0, 1'b0, o, md, c, iq, ien);
                left--;
            end else begin
                cycle(1'b0, 1'b0, o, md, c, iq, ien);
            end
            if (m_step == 0 && (md || !pre[B_WAIT])) break;
        end
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cur_op;
        int pick;
        void'($urandom(32'h5EED_1234));
        // R2: reset strobe and cleared state
        cycle(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 12, 1'b1, 1'b1, 1'b1, 1'b1);
        // R3: halted, inputs ignored
        cycle(1'b0, 1'b0, 12, 1'b1, 1'b0, 1'b1, 1'b1);
        cycle(1'b0, 1'b0, 26, 1'b0, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4 R7: add and add-immediate, R5 with delayed completion
        instr(12, 0, 0, 1'b0, 1'b0);
        instr(13, 2, 0, 1'b0, 1'b0);
        // R8: load and store with stalls
        instr(1, 1, 0, 1'b0, 1'b0);
        instr(3, 3, 0, 1'b0, 1'b0);
        // R9: branch
        instr(8, 0, 0, 1'b0, 1'b0);
        // R10: shift with three passes, then with zero count
        instr(26, 0, 3, 1'b0, 1'b0);
        instr(26, 1, 0, 1'b0, 1'b0);
        // R11: nop and unlisted opcode
        instr(0, 0, 0, 1'b0, 1'b0);
        instr(7, 0, 0, 1'b0, 1'b0);
        // R12: taken, then masked, then held across an instruction
        cycle(1'b0, 1'b0, 12, 1'b1, 1'b0, 1'b1, 1'b1);
        instr(12, 0, 0, 1'b1, 1'b0);
        cycle(1'b0, 1'b0, 12, 1'b1, 1'b0, 1'b0, 1'b0);
        instr(12, 0, 0, 1'b0, 1'b0);
        // R11: stop, then halted
        instr(31, 0, 0, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 12, 1'b1, 1'b0, 1'b1, 1'b1);
        cycle(1'b0, 1'b1, 12, 1'b1, 1'b0, 1'b0, 1'b0);
        // Random phase
        cur_op = 12;
        for (int i = 0; i < 4000; i++) begin
            if (m_step == 0) begin
                pick = int'($urandom % 10);
                case (pick)
                    0: cur_op = 0;  1: cur_op = 1;  2: cur_op = 3;  3: cur_op = 8;
                    4: cur_op = 12; 5: cur_op = 13; 6: cur_op = 26; 7: cur_op = 31;
                    8: cur_op = 26;
                    default: cur_op = int'($urandom % 32);
                endcase
            end
            cycle(($urandom % 300) == 0, ($urandom % 12) == 0, cur_op,
                  ($urandom % 3) != 0, ($urandom % 3) == 0,
                  ($urandom % 6) == 0, ($urandom % 2) == 0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule